// File: doc/BRIEF.md
# Serial Transmit Engine with Break Generation

This block turns parallel words into an asynchronous serial stream on a single output line. Each frame is a low start bit, then eight or nine data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A programmable divider sets the length of every bit to `baudDiv + 1` system clocks. One holding buffer sits in front of the shift register, so software can queue the next word while the current frame is on the line.

Two status flags report progress. `bufEmpty` shows that a word may be written. `txIdle` shows that the last frame has finished and the line is quiet. Both flags are sticky. Software clears them by pulsing a status read and then writing a word. A write that arrives while no frame is running goes straight into the shift register, so the buffer stays free. A break request makes the engine send a start bit followed by zeros in units of thirteen bit times. A new unit begins for as long as the request stays high. Once the request drops, the engine sends the normal stop bits.

Top module: `utx_top`

## Requirements
- R1: After reset `txOut` is 1, `bufEmpty` is 1 and `txIdle` is 1.
- R2: Every bit lasts `baudDiv + 1` clocks. A frame is a start bit (0), then the data bits least significant first, then the stop bits (1). The start bit begins on the clock edge that accepts the write.
- R3: When `wordNine` = 1 there are nine data bits. The ninth bit is `bit8In` as it was sampled at the write, and `dataIn` supplies bits 0 to 7. When `wordNine` = 0, `bit8In` has no effect.
- R4: When `parEn` = 1, a parity bit follows the data. With `parOdd` = 0 the data bits together with the parity bit hold an even number of ones; with `parOdd` = 1 they hold an odd number. When `twoStop` = 1 there are two stop bits, otherwise one.
- R5: A `dataWr` pulse is accepted only when all three of these hold: `statusRd` was pulsed in an earlier cycle since the previous `dataWr`, `bufEmpty` is 1, and `txEn` is 1. A write that is not accepted changes neither the line nor the flags.
- R6: An accepted write while no frame is running starts the frame at once. `bufEmpty` stays 1 and `txIdle` drops to 0.
- R7: An accepted write during a frame is held in the buffer and `bufEmpty` drops to 0. The held word starts right after the last stop bit of the current frame, with no gap, and `bufEmpty` returns to 1 at that point.
- R8: An accepted write in the final clock of a frame, while the buffer is empty, starts the next frame directly after the current one, and `bufEmpty` stays 1.
- R9: `txIdle` becomes 1 when a frame or a break ends and no further frame or break follows. `txIdle` falls only on an accepted write.
- R10: While `brkReq` is 1, the next transmission is a break: the line is low for 1 + 13·N bit times, where N is the number of 13-bit units that begin while `brkReq` is high, and then the stop bits follow. A break has priority over a held word. A break does not change `bufEmpty` or `irq`.
- R11: `irq` is `bufEmpty` AND `intEn`.
- R12: While `txEn` is 0, from the next clock on the line is high, any frame in progress and any held word are discarded, and `bufEmpty` and `txIdle` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEn | input | 1 | Transmitter enable |
| wordNine | input | 1 | 1 selects nine data bits |
| parEn | input | 1 | Parity bit enable |
| parOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| twoStop | input | 1 | 1 selects two stop bits |
| baudDiv | input | DIV_W | Bit time minus one, in clocks |
| dataIn | input | DATA_W | Data bits 0 to 7 for a write |
| bit8In | input | 1 | Ninth data bit for nine-bit frames |
| dataWr | input | 1 | Data write strobe |
| statusRd | input | 1 | Status read strobe, arms the next write |
| brkReq | input | 1 | Break request |
| intEn | input | 1 | Interrupt enable for buffer empty |
| txOut | output | 1 | Serial line |
| bufEmpty | output | 1 | Buffer can take a word |
| txIdle | output | 1 | Transmission complete and line quiet |
| irq | output | 1 | Interrupt request |

## Verification
The critical coincidence is a data write that lands in the same clock as the end of a frame. At that moment the engine must choose among three actions: start a held word, start the newly written word directly, or start a break that was requested earlier. The bench provokes this by counting clocks from the accepting edge of the first frame and placing the status read and the data write so that the write is accepted on the final edge of the last stop bit. It then compares every clock of both frames against the expected line levels. This check requires the two frames to run back to back and `bufEmpty` to stay high. A second case raises the break request during a data frame and checks that the break follows without a gap. In that case `txIdle` stays low until the break's stop bit has ended.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    LINE_HIGH = 2'd0,
    LINE_LOW  = 2'd1,
    LINE_DATA = 2'd2,
    LINE_PAR  = 2'd3
  } lineSel_t;

  typedef struct packed {
    logic     loadDirect;
    logic     loadBuf;
    logic     xferBuf;
    logic     shiftNext;
    lineSel_t lineSel;
  } dpCtl_t;

endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int BRK_LEN = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             wordNine,
  input  logic             parEn,
  input  logic             twoStop,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             dataWr,
  input  logic             statusRd,
  input  logic             brkReq,
  output dpCtl_t           ctl,
  output logic             bufEmpty,
  output logic             txIdle
);

  localparam int WORD_W = DATA_W + 1;
  localparam int MAXB   = (BRK_LEN > WORD_W) ? BRK_LEN : WORD_W;
  localparam int BIT_W  = $clog2(MAXB);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BRK
  } state_t;

  state_t            state;
  logic [DIV_W-1:0]  baudCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              armed;
  logic              brkFrame;

  logic tick, busy, acceptWr, frameEnd;
  logic goBreak, goXfer, goDirect, goBuffer, goIdle;
  logic [BIT_W-1:0] lastData;

  assign tick     = (baudCnt == baudDiv);
  assign busy     = (state != S_IDLE);
  assign acceptWr = dataWr & armed & bufEmpty & txEn;
  assign frameEnd = tick & (((state == S_STOP1) & ~twoStop) | (state == S_STOP2));
  assign lastData = wordNine ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  // next-frame decision, including the write-at-frame-end collision
  always_comb begin
    goBreak  = 1'b0;
    goXfer   = 1'b0;
    goDirect = 1'b0;
    goBuffer = 1'b0;
    goIdle   = 1'b0;
    if (txEn) begin
      if (!busy) begin
        goBreak  = brkReq;
        goDirect = acceptWr & ~brkReq;
        goBuffer = acceptWr & brkReq;
      end else if (frameEnd) begin
        if (brkReq) begin
          goBreak  = 1'b1;
          goBuffer = acceptWr;
        end else if (!bufEmpty) begin
          goXfer = 1'b1;
        end else if (acceptWr) begin
          goDirect = 1'b1;
        end else begin
          goIdle = 1'b1;
        end
      end else begin
        goBuffer = acceptWr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (statusRd) begin
      armed <= 1'b1;
    end else if (dataWr) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      baudCnt  <= '0;
      bitCnt   <= '0;
      brkFrame <= 1'b0;
      bufEmpty <= 1'b1;
      txIdle   <= 1'b1;
    end else if (!txEn) begin
      state    <= S_IDLE;
      baudCnt  <= '0;
      bitCnt   <= '0;
      brkFrame <= 1'b0;
      bufEmpty <= 1'b1;
      txIdle   <= 1'b1;
    end else begin
      if (goBuffer) begin
        bufEmpty <= 1'b0;
      end else if (goXfer) begin
        bufEmpty <= 1'b1;
      end
      if (acceptWr) begin
        txIdle <= 1'b0;
      end else if (goIdle) begin
        txIdle <= 1'b1;
      end
      if (goBreak | goXfer | goDirect) begin
        state    <= S_START;
        baudCnt  <= '0;
        bitCnt   <= '0;
        brkFrame <= goBreak;
      end else if (goIdle) begin
        state   <= S_IDLE;
        baudCnt <= '0;
      end else if (busy) begin
        if (!tick) begin
          baudCnt <= baudCnt + 1'b1;
        end else begin
          baudCnt <= '0;
          case (state)
            S_START: begin
              bitCnt <= '0;
              state  <= brkFrame ? S_BRK : S_DATA;
            end
            S_DATA: begin
              if (bitCnt == lastData) begin
                bitCnt <= '0;
                state  <= parEn ? S_PAR : S_STOP1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            S_PAR:   state <= S_STOP1;
            S_STOP1: state <= S_STOP2;
            S_BRK: begin
              if (bitCnt == BIT_W'(BRK_LEN - 1)) begin
                bitCnt <= '0;
                state  <= brkReq ? S_BRK : S_STOP1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    ctl.loadDirect = goDirect;
    ctl.loadBuf    = goBuffer;
    ctl.xferBuf    = goXfer;
    ctl.shiftNext  = (state == S_DATA) & tick;
    case (state)
      S_START, S_BRK: ctl.lineSel = LINE_LOW;
      S_DATA:         ctl.lineSel = LINE_DATA;
      S_PAR:          ctl.lineSel = LINE_PAR;
      default:        ctl.lineSel = LINE_HIGH;
    endcase
  end

  // R6: a direct start leaves the buffer free
  a_r6_direct_keeps_empty: assert property (@(posedge clk) disable iff (!rstN)
    (goDirect && !busy) |=> (bufEmpty && state == S_START));

  // R7: a held word moves into the shift register at frame end
  a_r7_xfer_starts: assert property (@(posedge clk) disable iff (!rstN)
    goXfer |=> (state == S_START && bufEmpty && !brkFrame));

  // R9: flags fall only after an accepted write
  a_r9_empty_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> $past(acceptWr));
  a_r9_idle_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txIdle) |-> $past(acceptWr));

  // R10: break units stay within their length and leave the buffer flag alone
  a_r10_brk_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BRK) |-> (bitCnt < BIT_W'(BRK_LEN)));
  a_r10_brk_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BRK && !acceptWr && txEn && !frameEnd) |=> $stable(bufEmpty));

  // R12: disable returns the engine to rest
  a_r12_disable_rest: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (state == S_IDLE && bufEmpty && txIdle));

endmodule

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              wordNine,
  input  logic              parOdd,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bit8In,
  output logic              txOut
);

  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] wrWord;
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;
  logic              parBit;

  assign wrWord = {bit8In & wordNine, dataIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctl.loadBuf) begin
      holdReg <= wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (ctl.loadDirect) begin
      shiftReg <= wrWord;
      parBit   <= (^wrWord) ^ parOdd;
    end else if (ctl.xferBuf) begin
      shiftReg <= holdReg;
      parBit   <= (^holdReg) ^ parOdd;
    end else if (ctl.shiftNext) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (ctl.lineSel)
      LINE_LOW:  txOut = 1'b0;
      LINE_DATA: txOut = shiftReg[0];
      LINE_PAR:  txOut = parBit;
      default:   txOut = 1'b1;
    endcase
  end

  // R2: the shift register is only ever loaded from one source per cycle
  a_r2_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.loadDirect, ctl.xferBuf, ctl.shiftNext}) <= 1);

  // R3: an eight-bit write never carries a ninth bit
  a_r3_ninth_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadDirect && !wordNine) |=> (shiftReg[WORD_W-1] == 1'b0));

endmodule

// File: rtl/utx_top.sv
module utx_top
  import utx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int BRK_LEN = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              wordNine,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              twoStop,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bit8In,
  input  logic              dataWr,
  input  logic              statusRd,
  input  logic              brkReq,
  input  logic              intEn,
  output logic              txOut,
  output logic              bufEmpty,
  output logic              txIdle,
  output logic              irq
);

  dpCtl_t ctl;

  utx_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BRK_LEN(BRK_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .wordNine(wordNine), .parEn(parEn),
    .twoStop(twoStop), .baudDiv(baudDiv), .dataWr(dataWr), .statusRd(statusRd),
    .brkReq(brkReq), .ctl(ctl), .bufEmpty(bufEmpty), .txIdle(txIdle)
  );

  utx_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordNine(wordNine), .parOdd(parOdd),
    .dataIn(dataIn), .bit8In(bit8In), .txOut(txOut)
  );

  assign irq = bufEmpty & intEn;

  // R11: a request is raised only while the buffer is free
  a_r11_irq_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> bufEmpty);

endmodule

// File: tb/sim_utx_top.sv
`timescale 1ns/100ps
module sim_utx_top;

  localparam int D = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b1, wordNine = 1'b0, parEn = 1'b0, parOdd = 1'b0, twoStop = 1'b0;
  logic [7:0] baudDiv = 8'(D);
  logic [7:0] dataIn = 8'h00;
  logic bit8In = 1'b0, dataWr = 1'b0, statusRd = 1'b0, brkReq = 1'b0, intEn = 1'b0;
  logic txOut, bufEmpty, txIdle, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  utx_top u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .wordNine(wordNine), .parEn(parEn),
    .parOdd(parOdd), .twoStop(twoStop), .baudDiv(baudDiv), .dataIn(dataIn),
    .bit8In(bit8In), .dataWr(dataWr), .statusRd(statusRd), .brkReq(brkReq),
    .intEn(intEn), .txOut(txOut), .bufEmpty(bufEmpty), .txIdle(txIdle), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one bit time of expected line level, starting and ending at a negedge
  task automatic expectBit(input logic v, input string req);
    for (int c = 0; c <= D; c++) begin
      chk(req, int'(txOut), int'(v));
      @(negedge clk);
    end
  endtask

  task automatic expectRun(input logic v, input int n, input string req);
    for (int i = 0; i < n; i++) expectBit(v, req);
  endtask

  task automatic expectFrame(input logic [7:0] d, input logic b8, input string req);
    logic [8:0] w;
    int nb;
    w  = {wordNine & b8, d};
    nb = wordNine ? 9 : 8;
    expectBit(1'b0, req);
    for (int i = 0; i < nb; i++) expectBit(w[i], req);
    if (parEn) expectBit((^w) ^ parOdd, req);
    expectBit(1'b1, req);
    if (twoStop) expectBit(1'b1, req);
  endtask

  task automatic doWrite(input logic [7:0] d, input logic b8);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    dataWr = 1'b1;
    dataIn = d;
    bit8In = b8;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 with interrupt disabled
    chk("R1 txOut", int'(txOut), 1);
    chk("R1 bufEmpty", int'(bufEmpty), 1);
    chk("R1 txIdle", int'(txIdle), 1);
    chk("R11 irq off", int'(irq), 0);
    intEn = 1'b1;
    @(negedge clk);
    chk("R11 irq on", int'(irq), 1);

    // R5: write without a prior status read is ignored
    dataWr = 1'b1; dataIn = 8'h55;
    @(negedge clk);
    dataWr = 1'b0;
    expectRun(1'b1, 4, "R5 unarmed write");
    chk("R5 idle kept", int'(txIdle), 1);

    // R2 R3 R4 R6 R9: format sweep
    for (int c = 0; c < 12; c++) begin
      wordNine = c[0];
      parEn    = ((c / 2) % 3) != 0;
      parOdd   = ((c / 2) % 3) == 2;
      twoStop  = (c / 6) != 0;
      for (int p = 0; p < 4; p++) begin
        doWrite(pats[p], p[0]);
        chk("R6 empty after direct", int'(bufEmpty), 1);
        chk("R6 idle cleared", int'(txIdle), 0);
        expectFrame(pats[p], p[0], "R2 R3 R4 frame");
        chk("R9 idle set", int'(txIdle), 1);
        chk("R9 line high", int'(txOut), 1);
      end
    end

    // R3 R4: all byte values, nine bits, even parity, two stops
    wordNine = 1'b1; parEn = 1'b1; parOdd = 1'b0; twoStop = 1'b1;
    for (int v = 0; v < 256; v++) begin
      doWrite(8'(v), v[0] ^ v[7]);
      expectFrame(8'(v), v[0] ^ v[7], "R3 R4 sweep");
    end

    // R7: buffered write, then a rejected third write (R5)
    wordNine = 1'b0; parEn = 1'b0; parOdd = 1'b0; twoStop = 1'b0;
    doWrite(8'h81, 1'b0);
    fork
      begin
        expectFrame(8'h81, 1'b0, "R7 first");
        chk("R7 empty after transfer", int'(bufEmpty), 1);
        expectFrame(8'h6E, 1'b0, "R7 held word");
      end
      begin
        repeat (4) @(negedge clk);
        doWrite(8'h6E, 1'b0);
        chk("R7 buffer full", int'(bufEmpty), 0);
        chk("R11 irq drops", int'(irq), 0);
        doWrite(8'h00, 1'b0);
      end
    join
    expectRun(1'b1, 2, "R5 full write dropped");
    chk("R9 idle after chain", int'(txIdle), 1);

    // R8: write accepted on the final edge of a frame
    doWrite(8'hC3, 1'b0);
    fork
      begin
        expectFrame(8'hC3, 1'b0, "R8 first");
        chk("R8 empty kept", int'(bufEmpty), 1);
        expectFrame(8'h1D, 1'b0, "R8 chained");
      end
      begin
        repeat (10 * (D + 1) - 2) @(negedge clk);
        statusRd = 1'b1;
        @(negedge clk);
        statusRd = 1'b0; dataWr = 1'b1; dataIn = 8'h1D; bit8In = 1'b0;
        @(negedge clk);
        dataWr = 1'b0;
      end
    join
    chk("R9 idle after R8", int'(txIdle), 1);

    // R10: single break unit from idle
    brkReq = 1'b1;
    @(negedge clk);
    fork
      expectRun(1'b0, 14, "R10 break N1");
      begin
        repeat (6) @(negedge clk);
        brkReq = 1'b0;
      end
    join
    chk("R10 irq unchanged", int'(irq), 1);
    expectBit(1'b1, "R10 stop");
    chk("R10 idle after break", int'(txIdle), 1);

    // R10: two units, two stop bits
    twoStop = 1'b1;
    brkReq = 1'b1;
    @(negedge clk);
    fork
      expectRun(1'b0, 27, "R10 break N2");
      begin
        repeat (20 * (D + 1)) @(negedge clk);
        brkReq = 1'b0;
      end
    join
    expectRun(1'b1, 2, "R10 stops");
    chk("R10 bufEmpty kept", int'(bufEmpty), 1);
    chk("R10 idle", int'(txIdle), 1);
    twoStop = 1'b0;

    // R9 R10: break requested during a data frame follows it
    doWrite(8'hF0, 1'b0);
    fork
      begin
        expectFrame(8'hF0, 1'b0, "R10 data before break");
        chk("R9 not idle before break", int'(txIdle), 0);
        expectRun(1'b0, 14, "R10 chained break");
        expectBit(1'b1, "R10 chained stop");
        chk("R9 idle after break", int'(txIdle), 1);
      end
      begin
        repeat (3) @(negedge clk);
        brkReq = 1'b1;
        repeat (40) @(negedge clk);
        brkReq = 1'b0;
      end
    join

    // R12: disable aborts frame and drops held word
    doWrite(8'h0F, 1'b0);
    doWrite(8'hAA, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12 pre buffer full", int'(bufEmpty), 0);
    txEn = 1'b0;
    @(negedge clk);
    chk("R12 line high", int'(txOut), 1);
    chk("R12 empty", int'(bufEmpty), 1);
    chk("R12 idle", int'(txIdle), 1);
    doWrite(8'h00, 1'b0);
    expectRun(1'b1, 3, "R5 disabled write");
    txEn = 1'b1;
    expectRun(1'b1, 4, "R12 held word dropped");
    doWrite(8'h5A, 1'b0);
    expectFrame(8'h5A, 1'b0, "R12 recovery");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule